// File: doc/BRIEF.md
# Two-Level Paging Address Translator

The block turns a 32-bit linear address into a 32-bit physical address using 4 KiB pages. A request is presented on a valid/ready input stream. The result leaves on a valid/ready output stream as a physical address together with a not-present error flag.

When paging is switched off, the address passes through unchanged. When paging is on, a 32-entry translation cache is searched first. A hit answers in the next cycle without touching memory. On a miss, a hardware walker makes two sequential single-beat reads: one for the directory entry and one for the page-table entry. A successful result is installed in the cache.

Writing a new directory base flushes the whole cache, which is what a task switch needs. Only one request is in flight at a time: `req_ready` stays low from acceptance until the response has been taken. A response that meets a low `rsp_ready` is held unchanged until it is accepted.

Top module: `pg_xlate`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0, `mem_rd_req` is 0 and the translation cache is empty.
- R2: With `pg_on` low when a request is accepted, the response carries `rsp_phys` equal to the linear address and `rsp_fault` 0. It makes no memory read and is valid in the cycle after acceptance.
- R3: On a cache miss with `pg_on` high, exactly two reads are made, in this order.
  - The first read is at `{dir_base[31:12], lin[31:22], 2'b00}`.
  - The second read is at `{pde[31:12], lin[21:12], 2'b00}`, where `pde` is the data returned by the first read.
  - The response is `{pte[31:12], lin[11:0]}` with `rsp_fault` 0, where `pte` is the data returned by the second read.
- R4: A request whose page (`lin[31:12]`) is held in the cache is answered in the cycle after acceptance with the cached frame and the request's own low 12 bits, and makes no memory read. No page is ever held twice.
- R5: Bit 0 of an entry is its present flag.
  - A directory entry with bit 0 clear ends the walk after one read.
  - A page-table entry with bit 0 clear ends the walk after two reads.
  - Both cases give `rsp_fault` 1 and `rsp_phys` 0, and nothing is installed, so a repeat of that request walks again.
- R6: The cache holds 32 pages. A new page fills the lowest-numbered empty slot. When no slot is empty, a round-robin pointer picks the victim; the pointer starts at slot 0 and advances by one after each such replacement.
- R7: A pulse on `base_wr` loads `base_in` as the directory base, empties the cache and resets the round-robin pointer to slot 0. Later walks use the new base.
- R8: `req_ready` is low from the cycle after a request is accepted until the cycle after its response handshake.
- R9: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid`, `rsp_phys` and `rsp_fault` keep their values.
- R10: `mem_rd_req` stays high with a stable `mem_rd_addr` until a cycle with `mem_rd_ack` high. `mem_rd_data` is taken in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pg_on | input | 1 | Paging enable, sampled when a request is accepted |
| base_wr | input | 1 | Directory base write strobe; also flushes the cache |
| base_in | input | 32 | New directory base (bits 11:0 ignored) |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready (block idle) |
| req_lin | input | 32 | Linear address of the request |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response accepted by the consumer |
| rsp_phys | output | 32 | Physical address (0 on fault) |
| rsp_fault | output | 1 | Not-present error |
| mem_rd_req | output | 1 | Table read request, held until acknowledged |
| mem_rd_addr | output | 32 | Byte address of the table entry |
| mem_rd_ack | input | 1 | Read data valid, one pulse per read |
| mem_rd_data | input | 32 | Table entry returned by memory |

## Verification
The assertions take three things for granted about the inputs.
- `mem_rd_ack` pulses for a single cycle, and only while `mem_rd_req` is high.
- `base_wr` is not pulsed while a walk is in progress.
- Stimulus for the stream handshakes follows valid/ready rules.

The bench's memory answers each read after a delay of one to three cycles and lowers the acknowledge in the following cycle. It changes the directory base only between transactions, with no request presented. It holds `rsp_ready` low for varying spans to exercise back-pressure.

// File: rtl/pgx_pkg.sv
package pgx_pkg;
  typedef enum logic [1:0] {
    XS_IDLE = 2'd0,
    XS_DIR  = 2'd1,
    XS_TBL  = 2'd2,
    XS_RSP  = 2'd3
  } xl_state_e;
endpackage

// File: rtl/pgx_tlb.sv
module pgx_tlb #(
  parameter int ENTRIES = 32,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic [PFN_W-1:0] lk_pfn,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PFN_W-1:0] fill_pfn
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] vld_q;
  logic [VPN_W-1:0]   tag_q [ENTRIES];
  logic [PFN_W-1:0]   pfn_q [ENTRIES];
  logic [ENTRIES-1:0] hit_vec;
  logic [IDX_W-1:0]   rr_q;
  logic [IDX_W-1:0]   free_idx;
  logic               free_found;
  logic [IDX_W-1:0]   victim;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = vld_q[g] && (tag_q[g] == lk_vpn);
  end

  always_comb begin
    lk_pfn = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (hit_vec[i]) lk_pfn = lk_pfn | pfn_q[i];
  end
  assign lk_hit = |hit_vec;

  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!vld_q[i]) begin
        free_found = 1'b1;
        free_idx   = IDX_W'(i);
      end
  end
  assign victim = free_found ? free_idx : rr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      rr_q  <= '0;
    end else if (flush) begin
      vld_q <= '0;
      rr_q  <= '0;
    end else if (fill_en) begin
      vld_q[victim] <= 1'b1;
      if (!free_found)
        rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en && !flush) begin
      tag_q[victim] <= fill_vpn;
      pfn_q[victim] <= fill_pfn;
    end
  end

  // R4
  no_dup_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // R6
  fill_takes_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !flush && free_found) |=> ($countones(vld_q) == $past($countones(vld_q)) + 1));

  // R7
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (vld_q == '0));
endmodule

// File: rtl/pgx_walker.sv
module pgx_walker
  import pgx_pkg::*;
#(
  parameter int AW    = 32,
  parameter int OFF_W = 12,
  parameter int IX_W  = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pg_on,
  input  logic [AW-OFF_W-1:0] dir_frame,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [AW-1:0]       req_lin,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [AW-1:0]       rsp_phys,
  output logic                rsp_fault,
  output logic [AW-OFF_W-1:0] lk_vpn,
  input  logic                lk_hit,
  input  logic [AW-OFF_W-1:0] lk_pfn,
  output logic                fill_en,
  output logic [AW-OFF_W-1:0] fill_vpn,
  output logic [AW-OFF_W-1:0] fill_pfn,
  output logic                mem_rd_req,
  output logic [AW-1:0]       mem_rd_addr,
  input  logic                mem_rd_ack,
  input  logic [AW-1:0]       mem_rd_data
);
  localparam int FN_W = AW - OFF_W;
  localparam int HI_LSB = OFF_W + IX_W;

  xl_state_e        st_q;
  logic [AW-1:0]    lin_q;
  logic [FN_W-1:0]  tbl_q;
  logic [AW-1:0]    phys_q;
  logic             fault_q;
  logic             accept;
  logic             present;

  assign req_ready  = (st_q == XS_IDLE);
  assign accept     = req_valid && req_ready;
  assign lk_vpn     = req_lin[AW-1:OFF_W];
  assign rsp_valid  = (st_q == XS_RSP);
  assign rsp_phys   = phys_q;
  assign rsp_fault  = fault_q;
  assign present    = mem_rd_data[0];
  assign mem_rd_req = (st_q == XS_DIR) || (st_q == XS_TBL);

  always_comb begin
    if (st_q == XS_TBL)
      mem_rd_addr = {tbl_q, lin_q[HI_LSB-1:OFF_W], 2'b00};
    else
      mem_rd_addr = {dir_frame, lin_q[AW-1:HI_LSB], 2'b00};
  end

  assign fill_en  = (st_q == XS_TBL) && mem_rd_ack && present;
  assign fill_vpn = lin_q[AW-1:OFF_W];
  assign fill_pfn = mem_rd_data[AW-1:OFF_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= XS_IDLE;
      lin_q   <= '0;
      tbl_q   <= '0;
      phys_q  <= '0;
      fault_q <= 1'b0;
    end else begin
      unique case (st_q)
        XS_IDLE: if (accept) begin
          lin_q   <= req_lin;
          fault_q <= 1'b0;
          if (!pg_on) begin
            phys_q <= req_lin;
            st_q   <= XS_RSP;
          end else if (lk_hit) begin
            phys_q <= {lk_pfn, req_lin[OFF_W-1:0]};
            st_q   <= XS_RSP;
          end else begin
            st_q   <= XS_DIR;
          end
        end
        XS_DIR: if (mem_rd_ack) begin
          if (present) begin
            tbl_q <= mem_rd_data[AW-1:OFF_W];
            st_q  <= XS_TBL;
          end else begin
            phys_q  <= '0;
            fault_q <= 1'b1;
            st_q    <= XS_RSP;
          end
        end
        XS_TBL: if (mem_rd_ack) begin
          phys_q  <= present ? {mem_rd_data[AW-1:OFF_W], lin_q[OFF_W-1:0]} : '0;
          fault_q <= !present;
          st_q    <= XS_RSP;
        end
        XS_RSP: if (rsp_ready) st_q <= XS_IDLE;
        default: st_q <= XS_IDLE;
      endcase
    end
  end

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && !mem_rd_ack) |=> (mem_rd_req && $stable(mem_rd_addr)));

  // R5
  dir_absent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == XS_DIR && mem_rd_ack && !present) |=> (rsp_valid && rsp_fault && rsp_phys == '0));

  // R2
  bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !pg_on) |=> (rsp_valid && !rsp_fault && rsp_phys == $past(req_lin)));
endmodule

// File: rtl/pg_xlate.sv
module pg_xlate #(
  parameter int AW      = 32,
  parameter int OFF_W   = 12,
  parameter int IX_W    = 10,
  parameter int ENTRIES = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pg_on,
  input  logic          base_wr,
  input  logic [AW-1:0] base_in,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_lin,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [AW-1:0] rsp_phys,
  output logic          rsp_fault,
  output logic          mem_rd_req,
  output logic [AW-1:0] mem_rd_addr,
  input  logic          mem_rd_ack,
  input  logic [AW-1:0] mem_rd_data
);
  localparam int FN_W = AW - OFF_W;

  logic [FN_W-1:0] dir_frame_q;
  logic [FN_W-1:0] lk_vpn, lk_pfn, fill_vpn, fill_pfn;
  logic            lk_hit, fill_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dir_frame_q <= '0;
    else if (base_wr) dir_frame_q <= base_in[AW-1:OFF_W];
  end

  pgx_tlb #(.ENTRIES(ENTRIES), .VPN_W(FN_W), .PFN_W(FN_W)) tlb_i (
    .clk(clk), .rst_n(rst_n), .flush(base_wr),
    .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_pfn(lk_pfn),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn)
  );

  pgx_walker #(.AW(AW), .OFF_W(OFF_W), .IX_W(IX_W)) walk_i (
    .clk(clk), .rst_n(rst_n), .pg_on(pg_on), .dir_frame(dir_frame_q),
    .req_valid(req_valid), .req_ready(req_ready), .req_lin(req_lin),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_phys(rsp_phys),
    .rsp_fault(rsp_fault), .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_pfn(lk_pfn),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_ack(mem_rd_ack), .mem_rd_data(mem_rd_data)
  );

  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_phys) && $stable(rsp_fault)));

  // R8
  one_in_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || mem_rd_req) |-> !req_ready);

  // R8
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
endmodule

// File: tb/pg_xlate_tb.sv
`timescale 1ns/100ps
module pg_xlate_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pg_on = 1'b0, base_wr = 1'b0, req_valid = 1'b0, rsp_ready = 1'b0;
  logic        mem_rd_ack = 1'b0;
  logic [31:0] base_in = '0, req_lin = '0, mem_rd_data = '0;
  logic        req_ready, rsp_valid, rsp_fault, mem_rd_req;
  logic [31:0] rsp_phys, mem_rd_addr;

  always #2.5 clk = ~clk;

  pg_xlate dut_i (
    .clk(clk), .rst_n(rst_n), .pg_on(pg_on), .base_wr(base_wr), .base_in(base_in),
    .req_valid(req_valid), .req_ready(req_ready), .req_lin(req_lin),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_phys(rsp_phys),
    .rsp_fault(rsp_fault), .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_ack(mem_rd_ack), .mem_rd_data(mem_rd_data)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", rq, act, exp, $time);
    end
  endtask

  // memory contents computed from the address
  function automatic logic [31:0] mem_fn(input logic [31:0] a);
    logic [19:0] fr;
    fr = a[31:12] ^ {a[11:2], a[11:2]} ^ 20'h5A5A3;
    return {fr, 11'h0, (a[11:2] != 10'h3FF)};
  endfunction

  // memory responder: 1..3 cycles per read
  int rd_cnt = 0, rd_total = 0, wcnt = 0;
  logic [31:0] rd_log [4];
  always @(negedge clk) begin
    if (mem_rd_ack) begin
      mem_rd_ack <= 1'b0;
      wcnt = 0;
    end else if (rst_n && mem_rd_req) begin
      wcnt++;
      if (wcnt >= 1 + (rd_total % 3)) begin
        mem_rd_ack  <= 1'b1;
        mem_rd_data <= mem_fn(mem_rd_addr);
        if (rd_cnt < 4) rd_log[rd_cnt] = mem_rd_addr;
        rd_cnt++;
        rd_total++;
      end
    end
  end

  // per-clock in-flight model for R8
  bit hs_in = 0, hs_out = 0, inflight = 0;
  always @(posedge clk) begin
    hs_in  = req_valid && req_ready;
    hs_out = rsp_valid && rsp_ready;
  end
  always @(negedge clk) begin
    if (!rst_n) inflight = 0;
    else begin
      if (hs_in) inflight = 1;
      if (hs_out) inflight = 0;
      check(req_ready == !inflight, "R8", {31'b0, req_ready}, {31'b0, !inflight});
    end
  end

  // reference translation cache
  logic [19:0] m_tag [32];
  logic [19:0] m_pfn [32];
  bit          m_vld [32];
  int          m_rr = 0;
  logic [19:0] m_base = '0;

  task automatic m_flush();
    for (int i = 0; i < 32; i++) m_vld[i] = 0;
    m_rr = 0;
  endtask

  task automatic set_base(input logic [31:0] b);
    @(negedge clk);
    base_wr = 1'b1; base_in = b;
    @(negedge clk);
    base_wr = 1'b0;
    m_base = b[31:12];
    m_flush();
  endtask

  task automatic xlate(input logic [31:0] lin, input int hold, input string rq);
    logic [31:0] e_phys, a0, a1, pde, pte, got_phys;
    bit e_fault, hit, got_fault;
    int e_reads, lat, slot;
    e_fault = 0; e_reads = 0; hit = 0; a0 = '0; a1 = '0;
    if (!pg_on) e_phys = lin;
    else begin
      for (int i = 0; i < 32; i++)
        if (m_vld[i] && m_tag[i] == lin[31:12]) begin
          hit = 1; e_phys = {m_pfn[i], lin[11:0]};
        end
      if (!hit) begin
        a0 = {m_base, lin[31:22], 2'b00};
        pde = mem_fn(a0);
        e_reads = 1;
        if (!pde[0]) begin e_fault = 1; e_phys = '0; end
        else begin
          a1 = {pde[31:12], lin[21:12], 2'b00};
          pte = mem_fn(a1);
          e_reads = 2;
          if (!pte[0]) begin e_fault = 1; e_phys = '0; end
          else begin
            e_phys = {pte[31:12], lin[11:0]};
            slot = -1;
            for (int i = 31; i >= 0; i--) if (!m_vld[i]) slot = i;
            if (slot < 0) begin slot = m_rr; m_rr = (m_rr + 1) % 32; end
            m_vld[slot] = 1; m_tag[slot] = lin[31:12]; m_pfn[slot] = pte[31:12];
          end
        end
      end
    end
    @(negedge clk);
    rd_cnt = 0;
    req_valid = 1'b1; req_lin = lin;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_valid) begin @(negedge clk); lat++; end
    got_phys = rsp_phys; got_fault = rsp_fault;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      check(rsp_valid && rsp_phys == got_phys && rsp_fault == got_fault, "R9", rsp_phys, got_phys);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    check(got_phys == e_phys, rq, got_phys, e_phys);
    check(got_fault == e_fault, rq, {31'b0, got_fault}, {31'b0, e_fault});
    check(rd_cnt == e_reads, rq, rd_cnt, e_reads);
    if (e_reads >= 1) check(rd_log[0] == a0, rq, rd_log[0], a0);
    if (e_reads == 2) check(rd_log[1] == a1, rq, rd_log[1], a1);
    if (e_reads == 0) check(lat == 1, rq, lat, 1);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    m_flush();
    repeat (3) @(negedge clk);
    // R1 reset state
    check(req_ready == 1 && rsp_valid == 0 && mem_rd_req == 0, "R1",
          {29'b0, req_ready, rsp_valid, mem_rd_req}, 32'h4);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 paging off
    xlate(32'h1234_5678, 0, "R2");
    pg_on = 1'b1;
    set_base(32'h0010_0ABC);
    // R3 walk, then R4 hit with back-pressure
    xlate(32'h0040_1ABC, 0, "R3");
    xlate(32'h0040_1FFF, 3, "R4");
    xlate(32'h0040_1000, 0, "R4");
    // R5 directory entry absent, twice; table entry absent, twice
    xlate(32'hFFC0_0123, 0, "R5");
    xlate(32'hFFC0_0456, 2, "R5");
    xlate(32'h0ABF_F010, 0, "R5");
    xlate(32'h0ABF_F020, 0, "R5");
    // R6 fill the remaining 31 slots, then force replacements
    for (int i = 0; i < 31; i++) xlate({10'h040, 10'(i), 12'h08}, 0, "R6");
    xlate({10'h040, 10'd31, 12'h0}, 0, "R6");
    xlate(32'h0040_1004, 0, "R6");
    xlate({10'h040, 10'd1, 12'h3}, 1, "R6");
    xlate({10'h040, 10'd0, 12'h5}, 0, "R6");
    // R7 new base flushes and redirects the walk
    set_base(32'h0020_0000);
    xlate({10'h040, 10'd2, 12'h77}, 0, "R7");
    xlate({10'h040, 10'd2, 12'h78}, 0, "R7");
    // R10 covered by every walk; R2 again after caching
    pg_on = 1'b0;
    xlate({10'h040, 10'd2, 12'h79}, 0, "R2");
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule